// File: doc/BRIEF.md
# Periodic Gate Event Collision Checker

This block decides whether a newly requested periodic gate schedule would ever fire an event at exactly the same instant as an event of a schedule that has already been accepted. Each schedule has a cycle time, a base time and an ordered list of interval lengths. Entry k of a list first fires at the schedule's reduced base time plus the sum of the intervals of entries 0 to k-1. It then repeats once every cycle time of its own schedule.

The surrounding logic writes both interval lists into two small internal memories through a simple write port. It places the schedule parameters on the inputs and pulses `start`. The block registers the parameters and then works through the problem one step at a time. A single shared remainder unit does the divisibility test and both base-time reductions, one after the other. A walker then merges the two occurrence streams of every entry pair. While it works, `busy` is high. When it finishes, `done` is raised and `collide`, `period_clash` and the two hit indices stay unchanged until the next accepted `start`.

Top module: `gate_collision_checker`

## Requirements
- R1: When `start` is high while the block is idle and the accepted slot is occupied, `busy` is high on the next cycle and stays high until `done` rises. `busy` and `done` are never high together. `done` stays low from the start until the result is ready.
- R2: When `start` arrives with `acc_valid` low, `done` rises on the next cycle with `collide`=0, `period_clash`=0 and both indices 0. No search is run.
- R3: When the larger cycle time is not an exact multiple of the smaller one, the result is `collide`=1 and `period_clash`=1 with both indices 0. No event is examined.
- R4: The reduced base time of each schedule is its base time modulo its own cycle time. A base time larger than the cycle time places events at that remainder.
- R5: Entry k of a list first occurs at reduced base time plus the sum of the intervals of entries 0..k-1. It recurs every cycle time of its own schedule.
- R6: Occurrences are compared only up to and including the window end. The window end is the larger cycle time plus the larger of the two reduced base times. A coincidence after the window end is not reported.
- R7: A collision is exact equality of two occurrence times. The pairs are searched in order: accepted index first, then new index, both ascending. The first colliding pair is reported on `hit_acc_idx`/`hit_new_idx` with `collide`=1 and `period_clash`=0.
- R8: `collide`=0 is reported only after every entry pair has been searched with no match. A list with a count of 0 has no events.
- R9: After `done`, the outputs hold until the next `start`. A `start` pulse while `busy` is high is ignored, along with the parameters presented with it.
- R10: A write with `wr_en`=1 stores `wr_data` at `wr_addr` in the accepted list when `wr_list`=0, or in the new list when `wr_list`=1. A later search uses the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | List write strobe |
| wr_list | input | 1 | Target list: 0 accepted, 1 new |
| wr_addr | input | AW | Entry index written |
| wr_data | input | IW | Interval value written |
| start | input | 1 | Begin a check (ignored while busy) |
| acc_valid | input | 1 | Accepted schedule slot is occupied |
| acc_cycle | input | TW | Accepted cycle time (nonzero) |
| acc_base | input | TW | Accepted base time |
| acc_count | input | AW+1 | Accepted entry count (saturates at DEPTH) |
| new_cycle | input | TW | New cycle time (nonzero) |
| new_base | input | TW | New base time |
| new_count | input | AW+1 | New entry count (saturates at DEPTH) |
| busy | output | 1 | Check in progress |
| done | output | 1 | Result valid |
| collide | output | 1 | A collision was found |
| period_clash | output | 1 | Collision declared because the cycle times are incommensurate |
| hit_acc_idx | output | AW | Accepted entry of the first colliding pair |
| hit_new_idx | output | AW | New entry of the first colliding pair |

## Verification
A wrong remainder or a wrong offset accumulator shows up as a changed `collide` bit or a changed index pair on the `done` cycle of the affected case. The indices expose an ordering fault even when the collide bit itself happens to be correct. A walker that steps the wrong stream, or that stops one step early or late, changes the verdict only in cases where a coincidence lies near the window end. The window-boundary cases therefore put the first match exactly at the end of the window and a second match one cycle beyond it. A fault in the handshake or the hold logic is visible within one cycle, because `busy`, `done` and the held result are compared on every clock against a behavioural model.

// File: rtl/gate_cc_pkg.sv
package gate_cc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_MGO   = 3'd1,
    ST_MWAIT = 3'd2,
    ST_LOAD  = 3'd3,
    ST_WALK  = 3'd4,
    ST_NEXT  = 3'd5
  } cc_state_e;

  typedef enum logic [1:0] {
    PH_DIVIDE = 2'd0,
    PH_RBT_A  = 2'd1,
    PH_RBT_N  = 2'd2
  } mod_phase_e;
endpackage

// File: rtl/gate_mod_unit.sv
module gate_mod_unit #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [TW-1:0] dividend,
  input  logic [TW-1:0] divisor,
  output logic          done,
  output logic [TW-1:0] rem
);
  localparam int CNTW = $clog2(TW + 1);

  logic            run_q, run_n;
  logic [CNTW-1:0] cnt_q, cnt_n;
  logic [TW-1:0]   sh_q, sh_n;
  logic [TW-1:0]   rem_q, rem_n;
  logic [TW-1:0]   dvs_q, dvs_n;
  logic            done_q, done_n;
  logic [TW:0]     trial, diff;

  assign trial = {rem_q, sh_q[TW-1]};
  assign diff  = trial - {1'b0, dvs_q};

  always_comb begin
    run_n  = run_q;
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    rem_n  = rem_q;
    dvs_n  = dvs_q;
    done_n = 1'b0;
    if (go) begin
      run_n = 1'b1;
      cnt_n = CNTW'(TW);
      sh_n  = dividend;
      rem_n = '0;
      dvs_n = divisor;
    end else if (run_q) begin
      rem_n = (trial >= {1'b0, dvs_q}) ? diff[TW-1:0] : trial[TW-1:0];
      sh_n  = {sh_q[TW-2:0], 1'b0};
      cnt_n = cnt_q - CNTW'(1);
      if (cnt_q == CNTW'(1)) begin
        run_n  = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      rem_q  <= rem_n;
      dvs_q  <= dvs_n;
      done_q <= done_n;
    end
  end

  assign done = done_q;
  assign rem  = rem_q;

  // R4: a finished remainder is always below its divisor
  p_rem_below_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && dvs_q != '0) |-> (rem_q < dvs_q));
endmodule

// File: rtl/gate_list_mem.sv
module gate_list_mem #(
  parameter int DEPTH = 8,
  parameter int IW    = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [IW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [IW-1:0] rdata
);
  logic [IW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/gate_collision_checker.sv
module gate_collision_checker
  import gate_cc_pkg::*;
#(
  parameter int TW    = 16,
  parameter int IW    = 16,
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_list,
  input  logic [AW-1:0] wr_addr,
  input  logic [IW-1:0] wr_data,
  input  logic          start,
  input  logic          acc_valid,
  input  logic [TW-1:0] acc_cycle,
  input  logic [TW-1:0] acc_base,
  input  logic [AW:0]   acc_count,
  input  logic [TW-1:0] new_cycle,
  input  logic [TW-1:0] new_base,
  input  logic [AW:0]   new_count,
  output logic          busy,
  output logic          done,
  output logic          collide,
  output logic          period_clash,
  output logic [AW-1:0] hit_acc_idx,
  output logic [AW-1:0] hit_new_idx
);
  localparam int MW = (IW > TW) ? IW : TW;
  localparam int EW = MW + AW + 3;
  localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rsync_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  // interval memories: index 0 accepted list, index 1 new list
  logic [IW-1:0] rd_data [2];
  logic [AW-1:0] rd_addr [2];
  logic [AW-1:0] i_q, i_n, j_q, j_n;

  assign rd_addr[0] = i_q;
  assign rd_addr[1] = j_q;

  for (genvar g = 0; g < 2; g++) begin : g_list
    gate_list_mem #(.DEPTH(DEPTH), .IW(IW), .AW(AW)) u_mem (
      .clk   (clk),
      .we    (wr_en && (wr_list == 1'(g))),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (rd_addr[g]),
      .rdata (rd_data[g])
    );
  end

  cc_state_e     state_q, state_n;
  mod_phase_e    phase_q, phase_n;
  logic [TW-1:0] ac_q, ac_n, ab_q, ab_n, nc_q, nc_n, nb_q, nb_n;
  logic [AW:0]   an_q, an_n, nn_q, nn_n;
  logic          av_q, av_n;
  logic [TW-1:0] rbt_a_q, rbt_a_n, rbt_n_q, rbt_n_n;
  logic [EW-1:0] d1_q, d1_n, d2_q, d2_n, t1_q, t1_n, t2_q, t2_n;
  logic          done_q, done_n, col_q, col_n, clash_q, clash_n;
  logic [AW-1:0] ha_q, ha_n, hn_q, hn_n;

  // shared remainder unit
  logic          mod_go, mod_done;
  logic [TW-1:0] mod_a, mod_b, mod_rem;
  logic [TW-1:0] max_c, min_c, max_rbt;
  logic [EW-1:0] win_end;

  assign max_c   = (ac_q >= nc_q) ? ac_q : nc_q;
  assign min_c   = (ac_q >= nc_q) ? nc_q : ac_q;
  assign max_rbt = (rbt_a_q >= rbt_n_q) ? rbt_a_q : rbt_n_q;
  assign win_end = EW'(max_c) + EW'(max_rbt);

  always_comb begin
    case (phase_q)
      PH_DIVIDE: begin mod_a = max_c; mod_b = min_c; end
      PH_RBT_A:  begin mod_a = ab_q;  mod_b = ac_q;  end
      default:   begin mod_a = nb_q;  mod_b = nc_q;  end
    endcase
  end

  gate_mod_unit #(.TW(TW)) u_mod (
    .clk      (clk),
    .rst_n    (rst_ns),
    .go       (mod_go),
    .dividend (mod_a),
    .divisor  (mod_b),
    .done     (mod_done),
    .rem      (mod_rem)
  );

  logic last_i, last_j;
  assign last_i = ({1'b0, i_q} == (an_q - (AW+1)'(1)));
  assign last_j = ({1'b0, j_q} == (nn_q - (AW+1)'(1)));

  // next-state process
  always_comb begin
    state_n = state_q;  phase_n = phase_q;
    ac_n = ac_q;  ab_n = ab_q;  an_n = an_q;
    nc_n = nc_q;  nb_n = nb_q;  nn_n = nn_q;  av_n = av_q;
    rbt_a_n = rbt_a_q;  rbt_n_n = rbt_n_q;
    d1_n = d1_q;  d2_n = d2_q;  t1_n = t1_q;  t2_n = t2_q;
    i_n = i_q;  j_n = j_q;
    done_n = done_q;  col_n = col_q;  clash_n = clash_q;
    ha_n = ha_q;  hn_n = hn_q;
    mod_go = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          ac_n = acc_cycle;  ab_n = acc_base;
          nc_n = new_cycle;  nb_n = new_base;
          an_n = (acc_count > DEPTH_C) ? DEPTH_C : acc_count;
          nn_n = (new_count > DEPTH_C) ? DEPTH_C : new_count;
          av_n = acc_valid;
          col_n = 1'b0;  clash_n = 1'b0;  ha_n = '0;  hn_n = '0;
          if (acc_valid) begin
            done_n  = 1'b0;
            phase_n = PH_DIVIDE;
            state_n = ST_MGO;
          end else begin
            done_n = 1'b1;
          end
        end
      end
      ST_MGO: begin
        mod_go  = 1'b1;
        state_n = ST_MWAIT;
      end
      ST_MWAIT: begin
        if (mod_done) begin
          case (phase_q)
            PH_DIVIDE: begin
              if (mod_rem != '0) begin
                col_n = 1'b1;  clash_n = 1'b1;  done_n = 1'b1;
                state_n = ST_IDLE;
              end else begin
                phase_n = PH_RBT_A;  state_n = ST_MGO;
              end
            end
            PH_RBT_A: begin
              rbt_a_n = mod_rem;
              phase_n = PH_RBT_N;  state_n = ST_MGO;
            end
            default: begin
              rbt_n_n = mod_rem;
              i_n = '0;  j_n = '0;  d1_n = '0;  d2_n = '0;
              if (an_q == '0 || nn_q == '0) begin
                done_n = 1'b1;  state_n = ST_IDLE;
              end else begin
                state_n = ST_LOAD;
              end
            end
          endcase
        end
      end
      ST_LOAD: begin
        t1_n = EW'(rbt_a_q) + d1_q;
        t2_n = EW'(rbt_n_q) + d2_q;
        state_n = ST_WALK;
      end
      ST_WALK: begin
        if (t1_q > win_end || t2_q > win_end) begin
          state_n = ST_NEXT;
        end else if (t1_q == t2_q) begin
          col_n = 1'b1;  ha_n = i_q;  hn_n = j_q;  done_n = 1'b1;
          state_n = ST_IDLE;
        end else if (t1_q < t2_q) begin
          t1_n = t1_q + EW'(ac_q);
        end else begin
          t2_n = t2_q + EW'(nc_q);
        end
      end
      ST_NEXT: begin
        state_n = ST_LOAD;
        if (last_j) begin
          j_n = '0;  d2_n = '0;
          if (last_i) begin
            done_n = 1'b1;  state_n = ST_IDLE;
          end else begin
            d1_n = d1_q + EW'(rd_data[0]);
            i_n  = i_q + AW'(1);
          end
        end else begin
          d2_n = d2_q + EW'(rd_data[1]);
          j_n  = j_q + AW'(1);
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_IDLE;  phase_q <= PH_DIVIDE;
      ac_q <= '0;  ab_q <= '0;  an_q <= '0;
      nc_q <= '0;  nb_q <= '0;  nn_q <= '0;  av_q <= 1'b0;
      rbt_a_q <= '0;  rbt_n_q <= '0;
      d1_q <= '0;  d2_q <= '0;  t1_q <= '0;  t2_q <= '0;
      i_q <= '0;  j_q <= '0;
      done_q <= 1'b0;  col_q <= 1'b0;  clash_q <= 1'b0;
      ha_q <= '0;  hn_q <= '0;
    end else begin
      state_q <= state_n;  phase_q <= phase_n;
      ac_q <= ac_n;  ab_q <= ab_n;  an_q <= an_n;
      nc_q <= nc_n;  nb_q <= nb_n;  nn_q <= nn_n;  av_q <= av_n;
      rbt_a_q <= rbt_a_n;  rbt_n_q <= rbt_n_n;
      d1_q <= d1_n;  d2_q <= d2_n;  t1_q <= t1_n;  t2_q <= t2_n;
      i_q <= i_n;  j_q <= j_n;
      done_q <= done_n;  col_q <= col_n;  clash_q <= clash_n;
      ha_q <= ha_n;  hn_q <= hn_n;
    end
  end

  assign busy         = (state_q != ST_IDLE);
  assign done         = done_q;
  assign collide      = col_q;
  assign period_clash = clash_q;
  assign hit_acc_idx  = ha_q;
  assign hit_new_idx  = hn_q;

  // R1: handshake outputs exclusive; an idle start with an occupied slot raises busy
  p_busy_done_excl_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    !(busy && done));
  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    (start && !busy && acc_valid) |=> busy);
  // R2: empty accepted slot never yields a collision
  p_empty_clear_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    (done && !av_q) |-> !collide);
  // R3: the period flag only comes with a collision
  p_clash_col_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    period_clash |-> collide);
  // R7: a reported pair lies inside both lists
  p_hit_range_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    (done && collide && !period_clash) |->
      ({1'b0, hit_acc_idx} < an_q && {1'b0, hit_new_idx} < nn_q));
  // R9: result held while no start
  p_hold_result_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    (done && !start) |=> (done && $stable({collide, period_clash, hit_acc_idx, hit_new_idx})));
  // R6: the walker never compares beyond the window end
  p_walk_window_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_WALK && state_n == ST_IDLE) |-> (t1_q <= win_end));
endmodule

// File: tb/test_gate_collision_checker.sv
module test_gate_collision_checker;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 16, IW = 16, DEPTH = 8, AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_list = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [IW-1:0] wr_data = '0;
  logic start = 1'b0, acc_valid = 1'b0;
  logic [TW-1:0] acc_cycle = '0, acc_base = '0, new_cycle = '0, new_base = '0;
  logic [AW:0] acc_count = '0, new_count = '0;
  logic busy, done, collide, period_clash;
  logic [AW-1:0] hit_acc_idx, hit_new_idx;

  int vectors = 0;
  int fails = 0;
  int acc_iv [DEPTH];
  int new_iv [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_collision_checker #(.TW(TW), .IW(IW), .DEPTH(DEPTH), .AW(AW)) i_gate_collision_checker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_list(wr_list), .wr_addr(wr_addr),
    .wr_data(wr_data), .start(start), .acc_valid(acc_valid), .acc_cycle(acc_cycle),
    .acc_base(acc_base), .acc_count(acc_count), .new_cycle(new_cycle), .new_base(new_base),
    .new_count(new_count), .busy(busy), .done(done), .collide(collide),
    .period_clash(period_clash), .hit_acc_idx(hit_acc_idx), .hit_new_idx(hit_new_idx));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference: exhaustive occurrence comparison
  task automatic ref_model(input bit v, input int ac, input int ab, input int an,
                           input int nc, input int nb, input int nn,
                           output bit col, output bit clash, output int ia, output int ja);
    int mx, mn, r1, r2, stop, d1, d2;
    bit found;
    col = 0; clash = 0; ia = 0; ja = 0; found = 0;
    if (!v) return;
    mx = (ac >= nc) ? ac : nc;
    mn = (ac >= nc) ? nc : ac;
    if (mx % mn != 0) begin col = 1; clash = 1; return; end
    r1 = ab % ac;  r2 = nb % nc;
    stop = mx + ((r1 > r2) ? r1 : r2);
    d1 = 0;
    for (int i = 0; i < an && !found; i++) begin
      d2 = 0;
      for (int j = 0; j < nn && !found; j++) begin
        for (int t1 = r1 + d1; t1 <= stop && !found; t1 += ac)
          for (int t2 = r2 + d2; t2 <= stop && !found; t2 += nc)
            if (t1 == t2) begin found = 1; col = 1; ia = i; ja = j; end
        d2 += new_iv[j];
      end
      d1 += acc_iv[i];
    end
  endtask

  task automatic load_lists();
    for (int k = 0; k < 2 * DEPTH; k++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_list = (k >= DEPTH);
      wr_addr = AW'(k % DEPTH);
      wr_data = IW'((k >= DEPTH) ? new_iv[k % DEPTH] : acc_iv[k % DEPTH]);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_case(input string req, input bit v, input int ac, input int ab, input int an,
                          input int nc, input int nb, input int nn, input bit poke);
    bit ecol, eclash;
    int eia, eja, guard;
    ref_model(v, ac, ab, an, nc, nb, nn, ecol, eclash, eia, eja);
    @(negedge clk);
    start = 1'b1; acc_valid = v;
    acc_cycle = TW'(ac); acc_base = TW'(ab); acc_count = (AW+1)'(an);
    new_cycle = TW'(nc); new_base = TW'(nb); new_count = (AW+1)'(nn);
    @(negedge clk);
    start = 1'b0;
    if (v) chk(busy == 1'b1 && done == 1'b0, "R1", "busy after start", busy, 1);
    else   chk(done == 1'b1 && busy == 1'b0, "R2", "done after start, empty slot", done, 1);
    if (poke && busy) begin
      // R9: a start during busy with other parameters is ignored
      start = 1'b1; acc_valid = 1'b1; acc_cycle = 16'd7; new_cycle = 16'd5;
      acc_base = 16'd3; new_base = 16'd1; acc_count = 4'd1; new_count = 4'd1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 30000) begin
      chk(busy == 1'b1, "R1", "busy held before done", busy, 1);
      @(negedge clk);
      guard++;
    end
    if (!done) begin
      chk(1'b0, req, "watchdog: done never rose", 0, 1);
      return;
    end
    for (int h = 0; h < 3; h++) begin
      chk(busy == 1'b0, "R1", "busy low with done", busy, 0);
      chk(collide == ecol, req, "collide", collide, ecol);
      chk(period_clash == eclash, req, "period_clash", period_clash, eclash);
      chk(int'(hit_acc_idx) == eia, req, "hit_acc_idx", hit_acc_idx, eia);
      chk(int'(hit_new_idx) == eja, req, "hit_new_idx", hit_new_idx, eja);
      if (h > 0) chk(done == 1'b1, "R9", "done held", done, 1);
      @(negedge clk);
    end
  endtask

  task automatic set_lists(input int a0, input int a1, input int n0, input int n1);
    for (int k = 0; k < DEPTH; k++) begin acc_iv[k] = 1; new_iv[k] = 1; end
    acc_iv[0] = a0; acc_iv[1] = a1; new_iv[0] = n0; new_iv[1] = n1;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    chk(1'b0, "R1", "global watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && collide == 0 && period_clash == 0, "R1", "reset state",
        {busy, done, collide, period_clash}, 0);

    set_lists(40, 60, 30, 20);
    load_lists();
    run_case("R2", 0, 100, 0, 2, 50, 10, 2, 0);          // empty accepted slot
    run_case("R3", 1, 100, 0, 2, 30, 10, 2, 0);          // incommensurate periods
    run_case("R7", 1, 100, 0, 2, 50, 10, 2, 0);          // match at pair (1,1)
    run_case("R9", 1, 100, 0, 2, 50, 10, 2, 1);          // start while busy ignored
    run_case("R8", 1, 100, 0, 2, 50, 10, 0, 0);          // new list empty
    run_case("R8", 1, 100, 0, 0, 50, 10, 2, 0);          // accepted list empty

    set_lists(66, 34, 10, 10);
    load_lists();
    run_case("R4", 1, 100, 1234, 2, 50, 84, 2, 0);       // base beyond cycle

    set_lists(30, 70, 20, 30);
    load_lists();
    run_case("R8", 1, 100, 1000, 2, 50, 5, 2, 0);        // full search, no match

    set_lists(100, 1, 260, 1);
    load_lists();
    run_case("R6", 1, 100, 60, 1, 200, 0, 2, 0);         // match exactly at window end
    set_lists(100, 1, 360, 1);
    load_lists();
    run_case("R6", 1, 100, 60, 1, 200, 0, 2, 0);         // match only beyond window end

    set_lists(40, 60, 30, 20);
    load_lists();
    @(negedge clk);
    wr_en = 1'b1; wr_list = 1'b0; wr_addr = 3'd0; wr_data = 16'd45;
    @(negedge clk);
    wr_en = 1'b0;
    acc_iv[0] = 45;
    run_case("R10", 1, 100, 0, 2, 50, 10, 2, 0);         // rewritten entry used

    for (int n = 0; n < 40; n++) begin
      int mn, k, an, nn, ac, nc;
      mn = $urandom_range(100, 20);
      k  = $urandom_range(4, 1);
      an = $urandom_range(4, 1);
      nn = $urandom_range(4, 1);
      for (int e = 0; e < DEPTH; e++) begin
        acc_iv[e] = $urandom_range(60, 1);
        new_iv[e] = $urandom_range(60, 1);
      end
      load_lists();
      if (n % 2 == 0) begin ac = mn * k; nc = mn; end
      else begin ac = mn; nc = mn * k + ((n % 5 == 1) ? 1 : 0); end
      run_case("R5", 1, ac, $urandom_range(500, 0), an, nc, $urandom_range(500, 0), nn, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule